// File: doc/BRIEF.md
# Quad Down-Counting Timer with Shared Interrupt Block

The block holds four independent 32-bit down-counters behind a simple word-addressed register bus. Each counter has its own clock divider, its own mode settings and a second reload value that can be changed while the counter runs. When a counter steps down to zero, it sets a bit in a status block that all four counters share. That block holds an interrupt mask, the raw status, the masked status and a write-one-to-clear register, and drives a single combined interrupt line.

Software loads a counter, picks its divider, mode and width, and enables it. For a fixed-rate tick, it changes the reload value without disturbing the period already in progress. For a timeout, it uses one-shot mode. For a monotonic time base that wraps, it uses free-running mode. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Reads are combinational from `bus_addr`.

Top module: `qct_timer_unit`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low.
- R2: Byte addresses (bits 1:0 ignored). 0x00 is the mask (read/write). 0x04 is the raw status. 0x08 is the masked status. 0x0C is the write-one-to-clear register and reads 0. Channel n occupies 0x10+0x10*n, with the load at +0, the current count at +4, the control at +8 and the reload value at +C. Any other address reads 0.
- R3: A write to the load offset copies the data into both the count and the reload value. A write to the reload offset changes only the reload value. Both offsets read back the reload value.
- R4: Control bit 7 enables the counter. While it is 0, the count holds its value.
- R5: Control bits 3:2 select the divider: 00 divides by 1, 01 by 16, and 10 or 11 by 256. The divider restarts whenever the enable is off. The first decrement therefore lands exactly D edges after the edge that writes the enable, where D is the divide ratio.
- R6: One-shot mode (control bit 0 = 1, which takes priority over bit 6) leaves the count at zero. Writing the control register so that the enable turns from 0 to 1 with bit 0 set, while the count is zero, reloads the count from the reload value.
- R7: Periodic mode (bit 0 = 0, bit 6 = 1) loads the reload value on the divider tick that finds the count at zero. The period is therefore reload+1 ticks.
- R8: Free-running mode (bit 0 = 0, bit 6 = 0) wraps a zero count to all ones of the active width.
- R9: Control bit 1 = 1 selects a 32-bit count. With bit 1 = 0, each tick clears bits 31:16, only bits 15:0 count and are tested for zero, the wrap value is 0x0000FFFF, and a reload takes only bits 15:0 of the reload value.
- R10: A tick that steps a counter from 1 to 0 sets that channel's raw status bit (bit n for channel n). The masked status equals raw AND mask. `irq` is the OR of the masked status.
- R11: Writing 1 to bit n at 0x0C clears raw bit n. If a zero event for channel n lands on the same edge, the bit stays set.
- R12: When a load write and a divider tick land on the same edge, the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_status | output | NUM_CH | Masked status per channel |
| irq | output | 1 | OR of the masked status |

## Verification
Two collisions matter most here, and each is forced on a known edge.

The first is a write-one-to-clear that lands on the same edge as a zero event. A counter loaded with 1 is enabled at divide-by-1, and the clear write is issued immediately afterwards. Both therefore fall on the next edge, and the raw bit must read back as set.

The second is a load write that meets a divider tick while a counter runs at divide-by-1. Reading the count right after the write must return the written value, not one less.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int CNT_W  = 32;
  localparam int HALF_W = CNT_W / 2;
  localparam int PRE_W  = 8;
  localparam int CTL_W  = 8;

  localparam int B_ONESHOT  = 0;
  localparam int B_WIDE     = 1;
  localparam int B_PRE_LO   = 2;
  localparam int B_PERIODIC = 6;
  localparam int B_ENABLE   = 7;

  typedef logic [CNT_W-1:0] cnt_t;

  // value as seen by the active width
  function automatic cnt_t eff_count(cnt_t c, logic wide);
    return wide ? c : {{(CNT_W-HALF_W){1'b0}}, c[HALF_W-1:0]};
  endfunction

  // next count on a divider tick
  function automatic cnt_t step_count(cnt_t c, cnt_t bg, logic wide,
                                      logic oneshot, logic periodic);
    cnt_t e;
    e = eff_count(c, wide);
    if (e != '0)   return e - cnt_t'(1);
    if (oneshot)   return '0;
    if (periodic)  return eff_count(bg, wide);
    return eff_count('1, wide);
  endfunction

  // terminal value of the divider counter
  function automatic logic [PRE_W-1:0] pre_limit(logic [1:0] sel);
    case (sel)
      2'd0:    return '0;
      2'd1:    return PRE_W'(15);
      default: return PRE_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/qct_prescaler.sv
module qct_prescaler
  import qct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] div_cnt;

  assign tick = run && (div_cnt >= pre_limit(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_cnt <= '0;
    else if (!run || tick) div_cnt <= '0;
    else                   div_cnt <= div_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_bg,
  input  logic             wr_ctl,
  input  cnt_t             wdata,
  output cnt_t             count,
  output cnt_t             bgval,
  output logic [CTL_W-1:0] ctl,
  output logic             zero_evt
);
  logic en, wide, oneshot, periodic, tick, rearm;

  assign en       = ctl[B_ENABLE];
  assign wide     = ctl[B_WIDE];
  assign oneshot  = ctl[B_ONESHOT];
  assign periodic = ctl[B_PERIODIC];

  qct_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en),
    .sel  (ctl[B_PRE_LO+1:B_PRE_LO]),
    .tick (tick)
  );

  // one-shot restart: enable rising while parked at zero
  assign rearm = wr_ctl && wdata[B_ENABLE] && !en && wdata[B_ONESHOT] &&
                 (eff_count(count, wdata[B_WIDE]) == '0);

  assign zero_evt = tick && en && !wr_load &&
                    (eff_count(count, wide) == cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      count <= '0;
      bgval <= '0;
    end else begin
      if (wr_ctl)           ctl   <= wdata[CTL_W-1:0];
      if (wr_load || wr_bg) bgval <= wdata;
      if (wr_load)          count <= wdata;
      else if (rearm)       count <= bgval;
      else if (tick && en)  count <= step_count(count, bgval, wide, oneshot, periodic);
    end
  end
endmodule

// File: rtl/qct_irq.sv
module qct_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mask,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] clr_hit,
  input  logic [N-1:0] evt,
  output logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      raw  <= '0;
    end else begin
      if (wr_mask) mask <= wdata;
      raw <= (raw & ~clr_hit) | evt;
    end
  end

  assign masked = raw & mask;
endmodule

// File: rtl/qct_timer_unit.sv
module qct_timer_unit
  import qct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_status,
  output logic              irq
);
  localparam int IRQ_WORDS = 4;
  localparam int CH_WORDS  = 4;

  logic [31:0] widx;
  logic        wr_en, wr_mask, wr_clr, unused_addr_bits;

  logic [NUM_CH-1:0]            zero_evt_v, clr_hit_v, wr_load_v, wr_bg_v, wr_ctl_v;
  logic [NUM_CH-1:0]            en_v, oneshot_v, mask_v, raw_v;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, bg_v;
  logic [NUM_CH-1:0][CTL_W-1:0] ctl_v;

  assign widx             = 32'(bus_addr[ADDR_W-1:2]);
  assign unused_addr_bits = ^bus_addr[1:0];
  assign wr_en            = bus_sel && bus_wr;
  assign wr_mask          = wr_en && (widx == 32'd0);
  assign wr_clr           = wr_en && (widx == 32'd3);
  assign clr_hit_v        = wr_clr ? bus_wdata[NUM_CH-1:0] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = IRQ_WORDS + CH_WORDS * i;
    assign wr_load_v[i] = wr_en && (widx == 32'(BASE));
    assign wr_ctl_v[i]  = wr_en && (widx == 32'(BASE + 2));
    assign wr_bg_v[i]   = wr_en && (widx == 32'(BASE + 3));

    qct_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_load (wr_load_v[i]),
      .wr_bg   (wr_bg_v[i]),
      .wr_ctl  (wr_ctl_v[i]),
      .wdata   (bus_wdata),
      .count   (cnt_v[i]),
      .bgval   (bg_v[i]),
      .ctl     (ctl_v[i]),
      .zero_evt(zero_evt_v[i])
    );

    assign en_v[i]      = ctl_v[i][B_ENABLE];
    assign oneshot_v[i] = ctl_v[i][B_ONESHOT];
  end

  qct_irq #(.N(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mask(wr_mask),
    .wdata  (bus_wdata[NUM_CH-1:0]),
    .clr_hit(clr_hit_v),
    .evt    (zero_evt_v),
    .mask   (mask_v),
    .raw    (raw_v),
    .masked (irq_status)
  );

  assign irq = |irq_status;

  always_comb begin
    bus_rdata = '0;
    if (widx == 32'd0) bus_rdata = 32'(mask_v);
    if (widx == 32'd1) bus_rdata = 32'(raw_v);
    if (widx == 32'd2) bus_rdata = 32'(irq_status);
    for (int k = 0; k < NUM_CH; k++) begin
      if (widx == 32'(IRQ_WORDS + CH_WORDS*k))     bus_rdata = bg_v[k];
      if (widx == 32'(IRQ_WORDS + CH_WORDS*k + 1)) bus_rdata = cnt_v[k];
      if (widx == 32'(IRQ_WORDS + CH_WORDS*k + 2)) bus_rdata = 32'(ctl_v[k]);
      if (widx == 32'(IRQ_WORDS + CH_WORDS*k + 3)) bus_rdata = bg_v[k];
    end
  end
endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
  parameter int N = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       evt,
  input logic [N-1:0]       clr,
  input logic [N-1:0]       raw,
  input logic [N-1:0]       en,
  input logic [N-1:0]       oneshot,
  input logic [N-1:0]       ld,
  input logic [N-1:0]       ctlwr,
  input logic [N-1:0][31:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_event_sets_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> raw[g]);

    assert_clear_drops_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !evt[g]) |=> !raw[g]);

    assert_raw_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[g] && !clr[g]) |=> raw[g]);

    assert_oneshot_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && oneshot[g] && cnt[g] == 32'd0 && !ld[g] && !ctlwr[g]) |=> cnt[g] == 32'd0);

    assert_disabled_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[g] && !ld[g] && !ctlwr[g]) |=> $stable(cnt[g]));
  end
endmodule

bind qct_timer_unit qct_checker #(.N(NUM_CH)) u_qct_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .evt    (zero_evt_v),
  .clr    (clr_hit_v),
  .raw    (raw_v),
  .en     (en_v),
  .oneshot(oneshot_v),
  .ld     (wr_load_v),
  .ctlwr  (wr_ctl_v),
  .cnt    (cnt_v)
);

// File: tb/test_qct_timer_unit.sv
`timescale 1ns/100ps
module test_qct_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_status;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qct_timer_unit i_qct_timer_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_status(irq_status),
    .irq       (irq)
  );

  localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MSKD = 8'h08, A_CLR = 8'h0C;

  function automatic logic [7:0] ca(int ch, int r);
    return 8'(16 + 16*ch + 4*r);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_MASK, v); check("R1 mask", v, 0);
    rd(A_RAW, v);  check("R1 raw", v, 0);
    rd(A_MSKD, v); check("R1 masked", v, 0);
    check("R1 irq", 32'(irq), 0);
    for (int c = 0; c < 4; c++) begin
      rd(ca(c, 1), v); check("R1 count", v, 0);
      rd(ca(c, 2), v); check("R1 ctrl", v, 0);
    end

    // R2 / R3 load and reload registers
    wr(ca(0, 0), 32'h1234);
    rd(ca(0, 1), v); check("R3 load->count", v, 32'h1234);
    rd(ca(0, 0), v); check("R3 load readback", v, 32'h1234);
    wr(ca(0, 3), 32'h55);
    rd(ca(0, 1), v); check("R3 bg leaves count", v, 32'h1234);
    rd(ca(0, 3), v); check("R3 bg readback", v, 32'h55);
    rd(8'h60, v);    check("R2 unmapped", v, 0);

    // R4 / R5 divider sweep on channel 1
    for (int s = 0; s < 4; s++) begin
      int d;
      d = (s == 0) ? 1 : (s == 1) ? 16 : 256;
      wr(ca(1, 2), 0);
      wr(ca(1, 0), 100);
      wr(ca(1, 2), 32'hC2 | 32'(s << 2));
      step(3*d - 1);
      rd(ca(1, 1), v); check("R5 before third tick", v, 98);
      step(1);
      rd(ca(1, 1), v); check("R5 third tick", v, 97);
      wr(ca(1, 2), 32'h42 | 32'(s << 2));
      rd(ca(1, 1), v);
      step(5);
      rd(ca(1, 1), w); check("R4 disabled holds", w, v);
      wr(ca(1, 2), 32'hC2 | 32'(s << 2));
      step(d - 1);
      rd(ca(1, 1), w); check("R5 restart no early tick", w, v);
      step(1);
      rd(ca(1, 1), w); check("R5 restart first tick", w, v - 1);
    end
    wr(ca(1, 2), 0);
    wr(A_CLR, 32'hF);

    // R6 one-shot on channel 0
    wr(ca(0, 0), 2);
    wr(ca(0, 2), 32'h83);
    step(5);
    rd(ca(0, 1), v); check("R6 parks at zero", v, 0);
    rd(A_RAW, v);    check("R10 raw bit0", v & 1, 1);
    wr(ca(0, 2), 0);
    wr(ca(0, 3), 9);
    rd(ca(0, 1), v); check("R3 bg write while parked", v, 0);
    wr(ca(0, 2), 32'h83);
    rd(ca(0, 1), v); check("R6 re-enable reloads", v, 9);
    wr(ca(0, 2), 0);

    // R7 periodic on channel 2
    wr(ca(2, 0), 3);
    wr(ca(2, 3), 7);
    wr(ca(2, 2), 32'hC2);
    step(2);
    rd(ca(2, 1), v); check("R7 count", v, 1);
    rd(A_RAW, v);    check("R10 raw bit2 early", (v >> 2) & 1, 0);
    step(1);
    rd(ca(2, 1), v); check("R7 zero", v, 0);
    rd(A_RAW, v);    check("R10 raw bit2 set", (v >> 2) & 1, 1);
    step(1);
    rd(ca(2, 1), v); check("R7 reload", v, 7);
    step(1);
    rd(ca(2, 1), v); check("R7 after reload", v, 6);
    wr(ca(2, 2), 0);

    // R10 / R11 mask, masked, irq, clear
    rd(A_RAW, v);  check("R10 raw bits", v, 32'h5);
    rd(A_MSKD, v); check("R10 masked none", v, 0);
    check("R10 irq low", 32'(irq), 0);
    wr(A_MASK, 32'h4);
    rd(A_MSKD, v); check("R10 masked", v, 32'h4);
    check("R10 irq high", 32'(irq), 1);
    wr(A_CLR, 32'h4);
    rd(A_RAW, v);  check("R11 clear one bit", v, 32'h1);
    check("R11 irq dropped", 32'(irq), 0);
    rd(A_CLR, v);  check("R2 clear reads zero", v, 0);
    wr(A_CLR, 32'h1);

    // R11 clear and zero event on the same edge, channel 3
    wr(ca(3, 0), 1);
    wr(ca(3, 2), 32'hC2);
    wr(A_CLR, 32'h8);
    rd(A_RAW, v);  check("R11 set wins over clear", v, 32'h8);
    wr(ca(3, 2), 0);
    wr(A_CLR, 32'h8);
    rd(A_RAW, v);  check("R11 cleared after stop", v, 0);
    rd(ca(3, 2), v); check("R2 ctrl readback", v, 0);

    // R8 free-running wrap, 32-bit, channel 1
    wr(ca(1, 0), 1);
    wr(ca(1, 2), 32'h82);
    step(1);
    rd(ca(1, 1), v); check("R8 reach zero", v, 0);
    step(1);
    rd(ca(1, 1), v); check("R8 wrap 32", v, 32'hFFFF_FFFF);
    step(1);
    rd(ca(1, 1), v); check("R8 after wrap", v, 32'hFFFF_FFFE);

    // R9 16-bit width
    wr(ca(1, 2), 0);
    wr(ca(1, 0), 32'h0001_0002);
    wr(ca(1, 2), 32'h80);
    step(1);
    rd(ca(1, 1), v); check("R9 upper cleared", v, 1);
    step(1);
    rd(ca(1, 1), v); check("R9 low zero", v, 0);
    step(1);
    rd(ca(1, 1), v); check("R9 wrap 16", v, 32'h0000_FFFF);
    wr(ca(1, 2), 0);
    wr(ca(1, 0), 32'h0003_0001);
    wr(ca(1, 3), 32'h1234_0005);
    wr(ca(1, 2), 32'hC0);
    step(1);
    rd(ca(1, 1), v); check("R9 zero on low half", v, 0);
    step(1);
    rd(ca(1, 1), v); check("R9 reload low half", v, 5);

    // R12 load write meets a tick
    wr(ca(1, 0), 32'h50);
    rd(ca(1, 1), v); check("R12 load wins", v, 32'h50);
    step(1);
    rd(ca(1, 1), v); check("R12 counts on", v, 32'h4F);
    wr(ca(1, 2), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule